// File: doc/BRIEF.md
# Signed Integer ALU with Status Flags

This block is a purely combinational arithmetic logic unit. It takes two operands of a parameterised width (32 bits by default) and a 4-bit operation code. It returns a result word together with three status bits: carry, zero and signed overflow. The operations are bitwise AND, OR and NOR, two's-complement addition and subtraction, a signed less-than test, and an equality test. Each test yields the word value 1 or 0.

The block is meant to sit in the execute stage of a simple integer datapath. The operation code arrives there already decoded, and the result and flags are registered downstream. Select codes outside the defined set give a known, quiet output. Two build-time options choose the implementation without changing any visible behaviour. One picks an explicit bit-level ripple carry chain or an arithmetic operator for the adder. The other picks whether the less-than test is taken from the subtractor's sign and overflow or from a dedicated signed comparator.

Top module: `sgn_alu`

## Requirements
- R1: Code 4'b0000 gives A AND B, code 4'b0001 gives A OR B, and code 4'b1100 gives NOT(A OR B). Each acts bit by bit over the full width.
- R2: Code 4'b0010 gives A + B modulo 2^WIDTH, and carry_out equals the carry leaving the most significant bit.
- R3: Code 4'b0110 gives A - B modulo 2^WIDTH, with carry_out 0.
- R4: For code 4'b0010, overflow is 1 exactly when A and B share a sign bit and the result's sign bit differs from it.
- R5: For code 4'b0110, overflow is 1 exactly when the sign bits of A and B differ and the result's sign bit differs from A's. For every code other than 4'b0010 and 4'b0110, overflow is 0.
- R6: Code 4'b0111 gives 1 when A < B as two's-complement numbers and 0 otherwise. This holds even when A - B overflows, for example A = most negative and B = 1.
- R7: Code 4'b1111 gives 1 when A equals B and 0 otherwise.
- R8: zero is 1 exactly when every result bit is 0, for every code.
- R9: Any code not listed in R1 to R7 gives a result of 0, carry_out 0 and overflow 0, so zero reads 1.
- R10: carry_out is 0 for every code other than 4'b0010.
- R11: All outputs are a function of the present inputs only, and hold no state from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the top bit, addition only |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of addition or subtraction |

## Verification
The bench builds two copies of the block. The first uses the default 32-bit width, the operator-based adder and the less-than test derived from the subtractor. The second is 8 bits wide and uses the explicit ripple chain and the dedicated signed comparator. The narrow copy makes random operands reach the overflow, carry and equality corners often: equal operands and sign-boundary sums turn up in a few hundred draws. The wide copy covers the full-width extremes through directed cases such as the most negative value minus one. Both copies are also fed all sixteen codes, which brings every undefined code into view.

// File: rtl/sgn_alu_pkg.sv
package sgn_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_AND = 4'b0000,
      OP_OR  = 4'b0001,
      OP_ADD = 4'b0010,
      OP_SUB = 4'b0110,
      OP_SLT = 4'b0111,
      OP_NOR = 4'b1100,
      OP_EQ  = 4'b1111
   } alu_op_e;

   typedef enum logic [1:0] {
      LFN_AND = 2'd0,
      LFN_OR  = 2'd1,
      LFN_NOR = 2'd2
   } logic_fn_e;

   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_LOGIC = 3'd1,
      SRC_SUM   = 3'd2,
      SRC_LESS  = 3'd3,
      SRC_EQUAL = 3'd4
   } res_src_e;

   typedef struct packed {
      res_src_e  src;
      logic_fn_e lfn;
      logic      subtract;
      logic      carry_en;
      logic      ovf_en;
   } alu_ctl_t;

   function automatic logic op_is_known(logic [OP_W-1:0] code);
      case (code)
         OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR, OP_EQ: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/sgn_alu_decode.sv
module sgn_alu_decode
   import sgn_alu_pkg::*;
(
   input  logic [OP_W-1:0] op_sel,
   output alu_ctl_t        ctl
);
   always_comb begin
      ctl          = '0;
      ctl.src      = SRC_NONE;
      ctl.lfn      = LFN_AND;
      case (op_sel)
         OP_AND: begin ctl.src = SRC_LOGIC; ctl.lfn = LFN_AND; end
         OP_OR:  begin ctl.src = SRC_LOGIC; ctl.lfn = LFN_OR;  end
         OP_NOR: begin ctl.src = SRC_LOGIC; ctl.lfn = LFN_NOR; end
         OP_ADD: begin
            ctl.src      = SRC_SUM;
            ctl.carry_en = 1'b1;
            ctl.ovf_en   = 1'b1;
         end
         OP_SUB: begin
            ctl.src      = SRC_SUM;
            ctl.subtract = 1'b1;
            ctl.ovf_en   = 1'b1;
         end
         OP_SLT: begin
            ctl.src      = SRC_LESS;
            ctl.subtract = 1'b1;
         end
         OP_EQ:  ctl.src = SRC_EQUAL;
         default: ctl.src = SRC_NONE;
      endcase
   end
endmodule

// File: rtl/sgn_alu_bitwise.sv
module sgn_alu_bitwise
   import sgn_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic_fn_e        lfn,
   output logic [WIDTH-1:0] y
);
   if (WIDTH < 1) begin : g_bad_width
      $error("sgn_alu_bitwise: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         case (lfn)
            LFN_AND: y[i] = a[i] & b[i];
            LFN_OR:  y[i] = a[i] | b[i];
            LFN_NOR: y[i] = ~(a[i] | b[i]);
            default: y[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/sgn_alu_addsub.sv
module sgn_alu_addsub #(
   parameter int WIDTH      = 32,
   parameter bit USE_RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum,
   output logic             carry_msb,
   output logic             ovf_raw
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sgn_alu_addsub: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] b_eff;
   assign b_eff = b ^ {WIDTH{subtract}};

   if (USE_RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = subtract;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
         assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
      end
      assign carry_msb = chain[WIDTH];
   end else begin : g_operator
      logic [WIDTH:0] wide;
      assign wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
      assign sum       = wide[WIDTH-1:0];
      assign carry_msb = wide[WIDTH];
   end

   // signs of both effective addends agree but the sum's sign does not
   assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/sgn_alu_compare.sv
module sgn_alu_compare #(
   parameter int WIDTH        = 32,
   parameter bit SLT_FROM_SUM = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             diff_msb,
   input  logic             diff_ovf,
   output logic             less,
   output logic             equal
);
   if (WIDTH < 2) begin : g_bad_width
      $error("sgn_alu_compare: WIDTH must be at least 2");
   end

   if (SLT_FROM_SUM) begin : g_from_sum
      // true sign of A-B is the raw sign corrected by overflow
      assign less = diff_msb ^ diff_ovf;
   end else begin : g_direct
      assign less = $signed(a) < $signed(b);
   end

   logic [WIDTH-1:0] same;
   for (genvar i = 0; i < WIDTH; i++) begin : g_xnor
      assign same[i] = ~(a[i] ^ b[i]);
   end
   assign equal = &same;
endmodule

// File: rtl/sgn_alu.sv
module sgn_alu
   import sgn_alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit USE_RIPPLE   = 1'b0,
   parameter bit SLT_FROM_SUM = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [OP_W-1:0]  op_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero,
   output logic             overflow
);
   if (WIDTH < 2) begin : g_bad_width
      $error("sgn_alu: WIDTH must be at least 2");
   end

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] logic_y;
   logic [WIDTH-1:0] sum;
   logic             carry_msb;
   logic             ovf_raw;
   logic             less;
   logic             equal;

   sgn_alu_decode u_decode (
      .op_sel (op_sel),
      .ctl    (ctl)
   );

   sgn_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a   (op_a),
      .b   (op_b),
      .lfn (ctl.lfn),
      .y   (logic_y)
   );

   sgn_alu_addsub #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) u_addsub (
      .a         (op_a),
      .b         (op_b),
      .subtract  (ctl.subtract),
      .sum       (sum),
      .carry_msb (carry_msb),
      .ovf_raw   (ovf_raw)
   );

   sgn_alu_compare #(.WIDTH(WIDTH), .SLT_FROM_SUM(SLT_FROM_SUM)) u_compare (
      .a        (op_a),
      .b        (op_b),
      .diff_msb (sum[WIDTH-1]),
      .diff_ovf (ovf_raw),
      .less     (less),
      .equal    (equal)
   );

   always_comb begin
      case (ctl.src)
         SRC_LOGIC: result = logic_y;
         SRC_SUM:   result = sum;
         SRC_LESS:  result = {{(WIDTH-1){1'b0}}, less};
         SRC_EQUAL: result = {{(WIDTH-1){1'b0}}, equal};
         default:   result = '0;
      endcase
   end

   assign carry_out = ctl.carry_en & carry_msb;
   assign overflow  = ctl.ovf_en & ovf_raw;
   assign zero      = ~|result;
endmodule

// File: rtl/sgn_alu_checker.sv
module sgn_alu_checker
   import sgn_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [OP_W-1:0]  op_sel,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             zero,
   input logic             overflow
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      // R10
      assert_carry_only_add_R10: assert (op_sel == OP_ADD || !carry_out)
         else $error("carry_out set for code %b", op_sel);
      // R5
      assert_ovf_only_arith_R5: assert (op_sel == OP_ADD || op_sel == OP_SUB || !overflow)
         else $error("overflow set for code %b", op_sel);
      // R4
      assert_add_ovf_signs_R4: assert (!(op_sel == OP_ADD && overflow) ||
                                       (op_a[MSB] == op_b[MSB] && result[MSB] != op_a[MSB]))
         else $error("add overflow without sign conflict");
      // R6
      assert_slt_signed_R6: assert (op_sel != OP_SLT ||
            result == {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))})
         else $error("set-less-than mismatch");
      // R7
      assert_eq_match_R7: assert (op_sel != OP_EQ ||
            result == {{(WIDTH-1){1'b0}}, (op_a == op_b)})
         else $error("equal compare mismatch");
      // R9
      assert_unknown_quiet_R9: assert (op_is_known(op_sel) ||
            (result == '0 && zero && !carry_out && !overflow))
         else $error("undefined code %b not quiet", op_sel);
      // R3
      assert_sub_value_R3: assert (op_sel != OP_SUB || result + op_b == op_a)
         else $error("subtract result does not restore A");
   end
endmodule

bind sgn_alu sgn_alu_checker #(.WIDTH(WIDTH)) u_sgn_alu_checker (
   .op_a      (op_a),
   .op_b      (op_b),
   .op_sel    (op_sel),
   .result    (result),
   .carry_out (carry_out),
   .zero      (zero),
   .overflow  (overflow)
);

// File: tb/test_sgn_alu.sv
module test_sgn_alu;

   localparam int WW = 32;
   localparam int NW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [WW-1:0] a, b;
   logic [3:0]    sel;
   logic [WW-1:0] w_res;
   logic          w_c, w_z, w_v;
   logic [NW-1:0] n_res;
   logic          n_c, n_z, n_v;

   int checks = 0;
   int errors = 0;

   sgn_alu #(.WIDTH(WW)) i_sgn_alu (
      .op_a(a), .op_b(b), .op_sel(sel),
      .result(w_res), .carry_out(w_c), .zero(w_z), .overflow(w_v)
   );

   sgn_alu #(.WIDTH(NW), .USE_RIPPLE(1'b1), .SLT_FROM_SUM(1'b0)) i_sgn_alu_narrow (
      .op_a(a[NW-1:0]), .op_b(b[NW-1:0]), .op_sel(sel),
      .result(n_res), .carry_out(n_c), .zero(n_z), .overflow(n_v)
   );

   function automatic void model(input int w, input logic [31:0] x, input logic [31:0] y,
                                 input logic [3:0] op, output logic [31:0] r,
                                 output logic c, output logic v);
      longint m, ux, uy, sx, sy, t, hi, lo, s;
      m  = (longint'(1) << w) - 1;
      ux = longint'(x) & m;
      uy = longint'(y) & m;
      sx = ((ux >> (w-1)) & 1) != 0 ? ux - (m + 1) : ux;
      sy = ((uy >> (w-1)) & 1) != 0 ? uy - (m + 1) : uy;
      hi = (longint'(1) << (w-1)) - 1;
      lo = -hi - 1;
      c = 1'b0; v = 1'b0; t = 0;
      case (op)
         4'b0000: t = ux & uy;
         4'b0001: t = ux | uy;
         4'b1100: t = ~(ux | uy);
         4'b0010: begin
            t = ux + uy;
            c = ((t >> w) & 1) != 0;
            s = sx + sy;
            v = (s > hi) || (s < lo);
         end
         4'b0110: begin
            t = ux - uy;
            s = sx - sy;
            v = (s > hi) || (s < lo);
         end
         4'b0111: t = (sx < sy) ? 1 : 0;
         4'b1111: t = (ux == uy) ? 1 : 0;
         default: t = 0;
      endcase
      r = 32'(t & m);
   endfunction

   function automatic string res_tag(input logic [3:0] op);
      case (op)
         4'b0000, 4'b0001, 4'b1100: return "R1";
         4'b0010: return "R2";
         4'b0110: return "R3";
         4'b0111: return "R6";
         4'b1111: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s sel=%b a=%h b=%h actual=%h expected=%h",
                  tag, what, sel, a, b, act, exp);
      end
   endtask

   task automatic compare_one(input string inst, input int w, input logic [31:0] res,
                              input logic c, input logic z, input logic v);
      logic [31:0] er;
      logic ec, ev;
      model(w, a, b, sel, er, ec, ev);
      check(res_tag(sel), {inst, " result"}, res, er);
      check(sel == 4'b0010 ? "R2" : "R10", {inst, " carry"}, 32'(c), 32'(ec));
      check(sel == 4'b0010 ? "R4" : "R5", {inst, " overflow"}, 32'(v), 32'(ev));
      check("R8", {inst, " zero"}, 32'(z), 32'(er == 32'd0));
   endtask

   task automatic apply(input logic [31:0] xa, input logic [31:0] xb, input logic [3:0] op);
      @(posedge clk);
      a = xa; b = xb; sel = op;
      @(negedge clk);
      compare_one("wide", WW, w_res, w_c, w_z, w_v);
      compare_one("narrow", NW, {24'd0, n_res}, n_c, n_z, n_v);
   endtask

   initial begin
      a = '0; b = '0; sel = 4'b0000;
      @(negedge clk);
      // initial output: AND of zeros gives zero result, zero flag set (R8, R11)
      compare_one("wide", WW, w_res, w_c, w_z, w_v);

      // directed mixed-sign vectors per operation
      apply(32'h086a0c31, 32'hd785f148, 4'b0000);   // R1
      apply(32'h086a0c31, 32'h10073fd4, 4'b0001);   // R1
      apply(32'h086a0c31, 32'h90073fd4, 4'b0010);   // R2
      apply(32'h086a0c31, 32'h90073fd4, 4'b0110);   // R3
      apply(32'h086a0c31, 32'h90073fd4, 4'b0111);   // R6
      apply(32'h086a0c31, 32'h90073fd4, 4'b1100);   // R1
      apply(32'h086a0c31, 32'h086a0c31, 4'b1111);   // R7 equal
      apply(32'h086a0c31, 32'h10073fd4, 4'b1111);   // R7 differ
      // corners
      apply(32'h7fffffff, 32'h00000001, 4'b0010);   // R4 positive overflow
      apply(32'h80000000, 32'h80000000, 4'b0010);   // R4 negative overflow, carry, zero
      apply(32'hffffffff, 32'h00000001, 4'b0010);   // R2 carry, R8 zero
      apply(32'h80000000, 32'h00000001, 4'b0110);   // R5 sub overflow
      apply(32'h00000001, 32'h80000000, 4'b0110);   // R5 sub overflow
      apply(32'h80000000, 32'h00000001, 4'b0111);   // R6 true with overflowing diff
      apply(32'h7fffffff, 32'h80000000, 4'b0111);   // R6 false with overflowing diff
      apply(32'h00000005, 32'h00000005, 4'b0110);   // R3 zero diff, R10 carry 0
      apply(32'h00000000, 32'h00000000, 4'b1100);   // R1 NOR all ones
      for (int k = 0; k < 16; k++) begin
         apply(32'hffffffff, 32'h12345678, 4'(k));  // R9 and every code
      end

      void'($urandom(32'd20240611));
      for (int n = 0; n < 2000; n++) begin
         logic [31:0] ra, rb;
         logic [3:0]  rop;
         ra  = $urandom;
         rb  = ($urandom_range(0, 7) == 0) ? ra : $urandom;
         if ($urandom_range(0, 3) == 0) ra = {ra[31], {31{~ra[31]}}};
         case ($urandom_range(0, 8))
            0: rop = 4'b0000;
            1: rop = 4'b0001;
            2: rop = 4'b0010;
            3: rop = 4'b0110;
            4: rop = 4'b0111;
            5: rop = 4'b1100;
            6: rop = 4'b1111;
            default: rop = 4'($urandom_range(0, 15));
         endcase
         apply(ra, rb, rop);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired before the stimulus ended");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule